// File: doc/BRIEF.md
# Banked Register File with Shadow Set

This block is the integer register storage of a processor core. It holds two complete banks of thirty-two 32-bit registers: the normal set and one shadow set. With the shadow set, an interrupt handler can run on its own registers, so the interrupted program's registers do not have to be saved and restored in memory. Two combinational read ports and one write port serve the pipeline. A write that lands in the same cycle as a read of the same register, in the same bank, is forwarded straight to the read port, so the read never returns a stale value.

Two select inputs come from outside the block. The current-set select names the bank that ordinary accesses use. The previous-set select names the bank that cross-set operations reach, so a handler can read or write the interrupted context's registers. Each read port and the write port carries its own flag that chooses between the two selects. A link flag on the write port sends the written value to the top register, whatever write index is given, which is how a return address gets stored. Register 0 is hard-wired to zero in every bank. The block has no state machine: it is pure storage, with an address decode in front and a forwarding multiplexer behind.

Top module: `shadow_regfile`

## Requirements
- R1: While rst_n is low, every register of both banks reads zero. The registers still read zero after reset is released and before any write.
- R2: With wr_prev = 0, a write goes to the bank named by cur_set (0 = normal set, 1 = shadow set). With a port's prev flag at 0, that port reads the bank named by cur_set.
- R3: The two read ports are independent, and both can read the same register in the same cycle.
- R4: When the write's bank and index both equal a read port's bank and index, that port returns wr_data in the same cycle, before the clock edge.
- R5: A write to the same index in a different bank is not forwarded. The read port returns the stored value of its own bank.
- R6: Index 0 reads zero from both ports in both banks. A write to index 0 changes nothing and is never forwarded.
- R7: A read port whose prev flag is 1 reads the bank named by prev_set.
- R8: With wr_prev = 1, a write goes to the bank named by prev_set.
- R9: While wr_link is 1, a write of wr_data to index 31 takes place, whatever the values of wr_en and wr_idx. The bank is chosen by wr_prev in the same way as for a normal write.
- R10: A write to one bank leaves the same index in the other bank unchanged.
- R11: While wr_en and wr_link are both 0, no register changes, whatever the values of wr_idx and wr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears both banks |
| cur_set | input | 1 | Bank used by ordinary accesses (0 normal, 1 shadow) |
| prev_set | input | 1 | Bank used by cross-set accesses (0 normal, 1 shadow) |
| wr_en | input | 1 | Write enable |
| wr_link | input | 1 | Write wr_data to register 31 |
| wr_prev | input | 1 | Write uses prev_set instead of cur_set |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 32 | Write data |
| ra_prev | input | 1 | Port A reads the bank named by prev_set |
| ra_idx | input | 5 | Port A register index |
| ra_data | output | 32 | Port A read data (combinational) |
| rb_prev | input | 1 | Port B reads the bank named by prev_set |
| rb_idx | input | 5 | Port B register index |
| rb_data | output | 32 | Port B read data (combinational) |

## Verification
The assertions check the following on every cycle:
- index 0 always reads zero;
- a forwarded write appears on port A in the same cycle;
- a link write is always steered to register 31;
- an idle write port never fires;
- a bank that is not written holds its contents across the edge;
- a committed write is stored at the index that was written.

The bench scenarios cover the behaviours that depend on a sequence of steps across both banks:
- a shadow write leaves the normal bank's copy untouched;
- cur_set and prev_set swap, and reads then follow the selects;
- a link write ignores the index it is given;
- a reset in the middle of a run wipes data written earlier.

// File: rtl/shadow_rf_pkg.sv
package shadow_rf_pkg;

    localparam int RF_DATA_W    = 32;
    localparam int RF_NUM_REGS  = 32;
    localparam int RF_NUM_BANKS = 2;

    // Which bank-select input an access follows
    typedef enum logic {
        SET_CURRENT  = 1'b0,
        SET_PREVIOUS = 1'b1
    } set_src_e;

    function automatic int sel_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/srf_write_ctrl.sv
module srf_write_ctrl
    import shadow_rf_pkg::*;
#(
    parameter int DATA_W   = RF_DATA_W,
    parameter int IDX_W    = 5,
    parameter int BSEL_W   = 1,
    parameter int LINK_IDX = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_link,
    input  logic              wr_prev,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BSEL_W-1:0] cur_set,
    input  logic [BSEL_W-1:0] prev_set,
    output logic              wfire,
    output logic [BSEL_W-1:0] wbank,
    output logic [IDX_W-1:0]  widx,
    output logic [DATA_W-1:0] wdata
);

    localparam logic [IDX_W-1:0] LINK_SEL = IDX_W'(LINK_IDX);

    set_src_e src;

    always_comb begin
        src   = set_src_e'(wr_prev);
        widx  = wr_link ? LINK_SEL : wr_idx;
        wdata = wr_data;
        unique case (src)
            SET_CURRENT:  wbank = cur_set;
            SET_PREVIOUS: wbank = prev_set;
            default:      wbank = cur_set;
        endcase
        wfire = (wr_en || wr_link) && (widx != '0);
    end

    // R9
    link_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_link |-> (wfire && widx == LINK_SEL));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !wr_link) |-> !wfire);

endmodule

// File: rtl/srf_bank.sv
module srf_bank
    import shadow_rf_pkg::*;
#(
    parameter int DATA_W   = RF_DATA_W,
    parameter int NUM_REGS = RF_NUM_REGS,
    parameter int IDX_W    = 5,
    parameter int NUM_RD   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [IDX_W-1:0]               widx,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic                            idx_ok;

    assign idx_ok = (widx != '0) && (int'(widx) < NUM_REGS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (we && idx_ok) begin
            regs[widx] <= wdata;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        always_comb begin
            if (rd_idx[p] == '0 || int'(rd_idx[p]) >= NUM_REGS) begin
                rd_data[p] = '0;
            end else begin
                rd_data[p] = regs[rd_idx[p]];
            end
        end
    end

    // R1
    bank_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (regs == '0));

    // R10
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs));

    // R2
    bank_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && widx != '0) |=> (regs[$past(widx)] == $past(wdata)));

endmodule

// File: rtl/srf_read_port.sv
module srf_read_port
    import shadow_rf_pkg::*;
#(
    parameter int DATA_W    = RF_DATA_W,
    parameter int IDX_W     = 5,
    parameter int BSEL_W    = 1,
    parameter int NUM_BANKS = RF_NUM_BANKS
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             use_prev,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [BSEL_W-1:0]                cur_set,
    input  logic [BSEL_W-1:0]                prev_set,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_words,
    input  logic                             wfire,
    input  logic [BSEL_W-1:0]                wbank,
    input  logic [IDX_W-1:0]                 widx,
    input  logic [DATA_W-1:0]                wdata,
    output logic [DATA_W-1:0]                rdata
);

    set_src_e          src;
    logic [BSEL_W-1:0] sel_bank;
    logic [DATA_W-1:0] stored;
    logic              hit;

    always_comb begin
        src = set_src_e'(use_prev);
        unique case (src)
            SET_CURRENT:  sel_bank = cur_set;
            SET_PREVIOUS: sel_bank = prev_set;
            default:      sel_bank = cur_set;
        endcase
        stored = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel_bank == BSEL_W'(b)) begin
                stored = bank_words[b];
            end
        end
        hit = wfire && (wbank == sel_bank) && (widx == idx) && (idx != '0);
        if (idx == '0) begin
            rdata = '0;
        end else if (hit) begin
            rdata = wdata;
        end else begin
            rdata = stored;
        end
    end

    // R6
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == '0) |-> (rdata == '0));

    // R7
    rd_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_prev && !wfire && idx != '0) |-> (rdata == bank_words[prev_set]));

endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
    import shadow_rf_pkg::*;
#(
    parameter  int DATA_W    = RF_DATA_W,
    parameter  int NUM_REGS  = RF_NUM_REGS,
    parameter  int NUM_BANKS = RF_NUM_BANKS,
    localparam int IDX_W     = $clog2(NUM_REGS),
    localparam int BSEL_W    = sel_bits(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BSEL_W-1:0] cur_set,
    input  logic [BSEL_W-1:0] prev_set,
    input  logic              wr_en,
    input  logic              wr_link,
    input  logic              wr_prev,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ra_prev,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic              rb_prev,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data
);

    localparam int NUM_RD   = 2;
    localparam int LINK_IDX = NUM_REGS - 1;

    logic              wfire;
    logic [BSEL_W-1:0] wbank;
    logic [IDX_W-1:0]  widx;
    logic [DATA_W-1:0] wdata;

    logic [NUM_RD-1:0][IDX_W-1:0]                    port_idx;
    logic [NUM_RD-1:0]                               port_prev;
    logic [NUM_RD-1:0][DATA_W-1:0]                   port_data;
    logic [NUM_BANKS-1:0][NUM_RD-1:0][DATA_W-1:0]    bank_rd;
    logic [NUM_RD-1:0][NUM_BANKS-1:0][DATA_W-1:0]    port_words;

    assign port_idx  = {rb_idx, ra_idx};
    assign port_prev = {rb_prev, ra_prev};
    assign ra_data   = port_data[0];
    assign rb_data   = port_data[1];

    srf_write_ctrl #(
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .BSEL_W   (BSEL_W),
        .LINK_IDX (LINK_IDX)
    ) u_wctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_link  (wr_link),
        .wr_prev  (wr_prev),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .cur_set  (cur_set),
        .prev_set (prev_set),
        .wfire    (wfire),
        .wbank    (wbank),
        .widx     (widx),
        .wdata    (wdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_we;
        assign bank_we = wfire && (wbank == BSEL_W'(b));

        srf_bank #(
            .DATA_W   (DATA_W),
            .NUM_REGS (NUM_REGS),
            .IDX_W    (IDX_W),
            .NUM_RD   (NUM_RD)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (bank_we),
            .widx    (widx),
            .wdata   (wdata),
            .rd_idx  (port_idx),
            .rd_data (bank_rd[b])
        );
    end

    always_comb begin
        for (int p = 0; p < NUM_RD; p++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                port_words[p][b] = bank_rd[b][p];
            end
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        srf_read_port #(
            .DATA_W    (DATA_W),
            .IDX_W     (IDX_W),
            .BSEL_W    (BSEL_W),
            .NUM_BANKS (NUM_BANKS)
        ) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .use_prev   (port_prev[p]),
            .idx        (port_idx[p]),
            .cur_set    (cur_set),
            .prev_set   (prev_set),
            .bank_words (port_words[p]),
            .wfire      (wfire),
            .wbank      (wbank),
            .widx       (widx),
            .wdata      (wdata),
            .rdata      (port_data[p])
        );
    end

    // R4
    ra_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_link && !wr_prev && !ra_prev && wr_idx == ra_idx && ra_idx != '0)
        |-> (ra_data == wr_data));

    // R9
    ra_link_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_link && wr_prev == ra_prev && ra_idx == IDX_W'(LINK_IDX))
        |-> (ra_data == wr_data));

endmodule

// File: tb/shadow_regfile_test.sv
module shadow_regfile_test;

    typedef struct packed {
        logic [31:0] tag;
        logic        w_en;
        logic        w_link;
        logic        w_prev;
        logic [4:0]  w_idx;
        logic [31:0] w_data;
        logic        cur;
        logic        prv;
        logic        a_prev;
        logic [4:0]  a_idx;
        logic        b_prev;
        logic [4:0]  b_idx;
        logic [31:0] exp_a;
        logic [31:0] exp_b;
    } vec_t;

    localparam int NV = 14;
    // Reads are checked before the clock edge; the write commits at that edge.
    localparam vec_t VECS [NV] = '{
        '{"R4",  1, 0, 0,  5, 32'hA5A50005, 0, 1, 0,  5, 1,  5, 32'hA5A50005, 32'h0},
        '{"R2",  0, 0, 0,  0, 32'h0,        0, 1, 0,  5, 1,  5, 32'hA5A50005, 32'h0},
        '{"R8",  1, 0, 1,  5, 32'h0000BEEF, 0, 1, 1,  5, 0,  5, 32'h0000BEEF, 32'hA5A50005},
        '{"R7",  0, 0, 0,  0, 32'h0,        1, 0, 0,  5, 1,  5, 32'h0000BEEF, 32'hA5A50005},
        '{"R6",  1, 0, 0,  0, 32'hFFFFFFFF, 1, 0, 0,  0, 1,  0, 32'h0,        32'h0},
        '{"R6",  0, 0, 0,  0, 32'h0,        1, 0, 0,  0, 0,  5, 32'h0,        32'h0000BEEF},
        '{"R9",  0, 1, 0,  7, 32'h12345678, 0, 1, 0, 31, 0,  7, 32'h12345678, 32'h0},
        '{"R9",  0, 0, 0,  0, 32'h0,        0, 1, 0, 31, 0,  7, 32'h12345678, 32'h0},
        '{"R11", 0, 0, 0,  9, 32'h0000DEAD, 0, 1, 0,  9, 1, 31, 32'h0,        32'h0},
        '{"R11", 0, 0, 0,  0, 32'h0,        0, 1, 0,  9, 0,  5, 32'h0,        32'hA5A50005},
        '{"R3",  1, 0, 0, 12, 32'h00000C0C, 0, 1, 0, 12, 0, 12, 32'h00000C0C, 32'h00000C0C},
        '{"R5",  1, 0, 0, 12, 32'h00001111, 0, 1, 0, 12, 1, 12, 32'h00001111, 32'h0},
        '{"R10", 0, 0, 0,  0, 32'h0,        0, 1, 0, 12, 1,  5, 32'h00001111, 32'h0000BEEF},
        '{"R4",  1, 0, 1, 20, 32'h00002020, 1, 1, 0, 20, 1, 20, 32'h00002020, 32'h00002020}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cur_set = 1'b0;
    logic        prev_set = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_link = 1'b0;
    logic        wr_prev = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        ra_prev = 1'b0;
    logic [4:0]  ra_idx = '0;
    logic [31:0] ra_data;
    logic        rb_prev = 1'b0;
    logic [4:0]  rb_idx = '0;
    logic [31:0] rb_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shadow_regfile uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_set  (cur_set),
        .prev_set (prev_set),
        .wr_en    (wr_en),
        .wr_link  (wr_link),
        .wr_prev  (wr_prev),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .ra_prev  (ra_prev),
        .ra_idx   (ra_idx),
        .ra_data  (ra_data),
        .rb_prev  (rb_prev),
        .rb_idx   (rb_idx),
        .rb_data  (rb_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; wr_link = 1'b0; wr_prev = 1'b0; wr_idx = '0; wr_data = '0;
    endtask

    task automatic set_reads(input logic ap, input logic [4:0] ai,
                             input logic bp, input logic [4:0] bi);
        ra_prev = ap; ra_idx = ai; rb_prev = bp; rb_idx = bi;
    endtask

    initial begin
        // Reset state: both banks read zero
        repeat (2) @(negedge clk);
        set_reads(0, 5'd5, 1, 5'd31);
        #5;
        check("R1 in reset", ra_data, 32'h0);
        check("R1 in reset", rb_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        check("R1 after release", ra_data, 32'h0);
        check("R1 after release", rb_data, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VECS[i].w_en; wr_link = VECS[i].w_link; wr_prev = VECS[i].w_prev;
            wr_idx = VECS[i].w_idx; wr_data = VECS[i].w_data;
            cur_set = VECS[i].cur; prev_set = VECS[i].prv;
            set_reads(VECS[i].a_prev, VECS[i].a_idx, VECS[i].b_prev, VECS[i].b_idx);
            #5;
            check($sformatf("%s vec %0d port A", VECS[i].tag, i), ra_data, VECS[i].exp_a);
            check($sformatf("%s vec %0d port B", VECS[i].tag, i), rb_data, VECS[i].exp_b);
        end

        // R9 with R8: link write to the previous set, index input ignored
        @(negedge clk);
        cur_set = 1'b0; prev_set = 1'b1;
        wr_en = 1'b0; wr_link = 1'b1; wr_prev = 1'b1; wr_idx = 5'd3; wr_data = 32'hCAFE0031;
        set_reads(1, 5'd31, 0, 5'd31);
        #5;
        check("R9 link forward", ra_data, 32'hCAFE0031);
        check("R9 link other bank", rb_data, 32'h12345678);
        @(negedge clk);
        idle();
        set_reads(1, 5'd31, 1, 5'd3);
        #5;
        check("R8 link stored prev", ra_data, 32'hCAFE0031);
        check("R9 index ignored", rb_data, 32'h0);

        // R1: reset in the middle of a run wipes both banks
        @(negedge clk);
        rst_n = 1'b0;
        set_reads(0, 5'd5, 1, 5'd5);
        #5;
        check("R1 mid-run bank0", ra_data, 32'h0);
        check("R1 mid-run bank1", rb_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        set_reads(0, 5'd12, 1, 5'd20);
        #5;
        check("R1 cleared r12", ra_data, 32'h0);
        check("R1 cleared r20", rb_data, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule